// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This unit watches the already-synchronized input levels of one GPIO bank (32 pins by default) and turns them into interrupt requests. Each pin is set up on its own to fire on a rising edge, a falling edge, either edge, a high level or a low level. A detected condition is latched into a sticky per-pin status bit. The pin is signalled only when it is also unmasked, and every pending pin is merged into a single registered interrupt line.

Software reaches the unit through a simple single-cycle register port with one shared word address. The trigger-kind, sense and both-edge registers are plain read/write. The mask is changed only by write-one unmask and mask strobes. Status bits are cleared by writing one to them. Detection never stops while a pin is masked, so a condition seen during masking is reported as soon as the pin is unmasked. Software that does not want such stale events clears the status bit before it unmasks the pin.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is low and directly after it, mask reads 0xFFFFFFFF (all pins masked), and status, trigger-kind, sense and both-edge read 0. The interrupt output is 0.
- R2: Word address map on `reg_addr`:
  - 0: mask (read-only, 1 = masked)
  - 1: unmask strobe (write-only)
  - 2: mask strobe (write-only)
  - 3: status (read, write-one-to-clear)
  - 4: trigger kind (1 = edge, 0 = level)
  - 5: sense (1 = rising/high, 0 = falling/low)
  - 6: both-edge
  - Reads of addresses 1, 2 and 7 return 0. Reads are combinational. A write takes effect on the clock edge that samples `reg_wr`.
- R3: In edge mode with both-edge 0, a pin with sense 1 sets its status bit only on a 0-to-1 change, and a pin with sense 0 only on a 1-to-0 change. The bit is set on the clock edge that first samples the new level.
- R4: In edge mode, a pin with its both-edge bit set triggers on either change whatever its sense bit is. In level mode the both-edge bit has no effect.
- R5: In level mode, a status bit is set on every clock edge at which the pin equals its sense bit. A clear made while that holds has no lasting effect.
- R6: Writing to the unmask strobe clears the mask bits where the data is 1. Writing to the mask strobe sets them where the data is 1. Zero data bits leave the mask unchanged, and writing all ones to the mask strobe masks every pin.
- R7: Writing to status clears exactly the bits where the data is 1. Other bits are unchanged.
- R8: When a new event and a clear of the same status bit fall on the same clock edge, the bit stays set.
- R9: Detection latches into status while a pin is masked. The interrupt rises one clock after the pin is unmasked.
- R10: The interrupt output is a register equal to the OR over pins of (status AND NOT mask) as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NPINS | Synchronized pin levels |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address for read and write |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Read data for `reg_addr` |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The assertions assume that `pin_lvl` is already synchronous to `clk` and that `reg_addr` and `reg_wdata` hold steady while `reg_wr` is high at a clock edge. The bench keeps to this by changing every input only on the falling clock edge and by keeping unused pins high while they sit in the reset level-low mode, so no stray events arise. Simultaneous cases, such as a clear together with a new event, are produced on purpose by one combined drive on the same falling edge.

// File: rtl/gpint_pkg.sv
// Package: shared constants and register selectors for the GPIO interrupt unit.
// Assumes a word-addressed register port with a 3-bit address.
package gpint_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK     = 3'd0,  // read-only mask, 1 = masked
        SEL_UNMASK   = 3'd1,  // write-one unmask strobe
        SEL_MASKSET  = 3'd2,  // write-one mask strobe
        SEL_STATUS   = 3'd3,  // sticky status, write-one-to-clear
        SEL_KIND     = 3'd4,  // 1 = edge, 0 = level
        SEL_SENSE    = 3'd5,  // 1 = rising/high, 0 = falling/low
        SEL_BOTH     = 3'd6,  // both-edge enable
        SEL_SPARE    = 3'd7   // reserved, reads 0
    } reg_sel_e;

endpackage

// File: rtl/gpint_cfg.sv
// Module: gpint_cfg
// Holds the per-pin trigger configuration and the interrupt mask.
// Assumes: write data is stable while reg_wr is high at a clock edge.
// The mask only moves through the unmask and mask-set strobes.
module gpint_cfg
    import gpint_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  kind_q,
    output logic [NPINS-1:0]  sense_q,
    output logic [NPINS-1:0]  both_q,
    output logic [NPINS-1:0]  mask_q
);

    localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};

    logic wr_kind, wr_sense, wr_both, wr_unmask, wr_maskset;

    // Decode the write strobes for each configuration target.
    always_comb begin
        wr_kind    = reg_wr && (reg_addr == SEL_KIND);
        wr_sense   = reg_wr && (reg_addr == SEL_SENSE);
        wr_both    = reg_wr && (reg_addr == SEL_BOTH);
        wr_unmask  = reg_wr && (reg_addr == SEL_UNMASK);
        wr_maskset = reg_wr && (reg_addr == SEL_MASKSET);
    end

    // Plain read/write trigger configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= '0;
            sense_q <= '0;
            both_q  <= '0;
        end else begin
            if (wr_kind)  kind_q  <= reg_wdata;
            if (wr_sense) sense_q <= reg_wdata;
            if (wr_both)  both_q  <= reg_wdata;
        end
    end

    // Mask register: write-one strobes set or clear individual bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= ALL_ONES;
        end else if (wr_unmask) begin
            mask_q <= mask_q & ~reg_wdata;
        end else if (wr_maskset) begin
            mask_q <= mask_q | reg_wdata;
        end
    end

    AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unmask |=> ((mask_q & $past(reg_wdata)) == '0)); // R6

    AST_MASKSET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_maskset |=> ((mask_q & $past(reg_wdata)) == $past(reg_wdata))); // R6

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_unmask || wr_maskset) |=> $stable(mask_q)); // R6

endmodule

// File: rtl/gpint_detect.sv
// Module: gpint_detect
// Turns pin levels into one-cycle event pulses, per pin, from the trigger config.
// Assumes: pin_lvl is already synchronous to clk. The previous-level register
// follows the pins during reset too, so no edge is seen on leaving reset.
module gpint_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] kind_q,
    input  logic [NPINS-1:0] sense_q,
    input  logic [NPINS-1:0] both_q,
    output logic [NPINS-1:0] event_vec
);

    logic [NPINS-1:0] prev_q;

    // Remember the level seen at the last clock edge for edge detection.
    always_ff @(posedge clk) begin
        prev_q <= pin_lvl;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic rise, fall, edge_hit, level_hit;

        // Per-pin event: edge or level condition selected by the config bits.
        always_comb begin
            rise      = pin_lvl[p] & ~prev_q[p];
            fall      = ~pin_lvl[p] & prev_q[p];
            edge_hit  = both_q[p] ? (rise | fall)
                                  : (sense_q[p] ? rise : fall);
            level_hit = (pin_lvl[p] == sense_q[p]);
            event_vec[p] = kind_q[p] ? edge_hit : level_hit;
        end
    end

    AST_LEVEL_EVENT: assert property (@(posedge clk)
        ((~kind_q & ~(pin_lvl ^ sense_q)) & ~event_vec) == '0); // R5

endmodule

// File: rtl/gpint_status.sv
// Module: gpint_status
// Sticky per-pin status with write-one clear, and the registered interrupt.
// Assumes: clr_vec is nonzero only in a cycle that writes the status address.
// A new event on the same edge as a clear keeps the bit set.
module gpint_status #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] event_vec,
    input  logic [NPINS-1:0] clr_vec,
    input  logic [NPINS-1:0] mask_q,
    output logic [NPINS-1:0] status_q,
    output logic             irq_q
);

    logic [NPINS-1:0] pending;

    // Pending set: latched conditions whose pin is unmasked.
    always_comb begin
        pending = status_q & ~mask_q;
    end

    // Status latch: clear on write-one, then OR in the new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | event_vec;
        end
    end

    // Registered interrupt request from any pending pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |pending;
        end
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_q) & ~$past(clr_vec)) & ~status_q) == '0)); // R7

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(event_vec) & ~status_q) == '0)); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~mask_q) == '0) |=> !irq_q); // R10

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~mask_q) != '0) |=> irq_q); // R9

endmodule

// File: rtl/gpio_irq_unit.sv
// Module: gpio_irq_unit (top)
// Interrupt detect and mask unit for one GPIO bank: configuration, detection,
// sticky status and the combined interrupt, plus the register read mux.
// Assumes: pins are pre-synchronized. Reads are combinational and writes act
// on the sampling clock edge.
module gpio_irq_unit
    import gpint_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_lvl,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              irq
);

    logic [NPINS-1:0] kind_q, sense_q, both_q, mask_q;
    logic [NPINS-1:0] event_vec, clr_vec, status_q;

    gpint_cfg #(.NPINS(NPINS)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .kind_q    (kind_q),
        .sense_q   (sense_q),
        .both_q    (both_q),
        .mask_q    (mask_q)
    );

    gpint_detect #(.NPINS(NPINS)) i_detect (
        .clk       (clk),
        .pin_lvl   (pin_lvl),
        .kind_q    (kind_q),
        .sense_q   (sense_q),
        .both_q    (both_q),
        .event_vec (event_vec)
    );

    // Write-one-to-clear vector for the status register.
    always_comb begin
        clr_vec = (reg_wr && (reg_addr == SEL_STATUS)) ? reg_wdata : '0;
    end

    gpint_status #(.NPINS(NPINS)) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_vec (event_vec),
        .clr_vec   (clr_vec),
        .mask_q    (mask_q),
        .status_q  (status_q),
        .irq_q     (irq)
    );

    // Read mux: write-only strobes and the spare address read as zero.
    always_comb begin
        case (reg_addr)
            SEL_MASK:   reg_rdata = mask_q;
            SEL_STATUS: reg_rdata = status_q;
            SEL_KIND:   reg_rdata = kind_q;
            SEL_SENSE:  reg_rdata = sense_q;
            SEL_BOTH:   reg_rdata = both_q;
            default:    reg_rdata = '0;
        endcase
    end

    AST_RESET_MASKED: assert property (@(posedge clk)
        !rst_n |=> (mask_q == {NPINS{1'b1}}) && !irq); // R1

endmodule

// File: tb/test_gpio_irq_unit.sv
// Directed bench for gpio_irq_unit: one task per scenario, each checking itself.
module test_gpio_irq_unit;

    localparam int  NP = 32;
    localparam time CLK_PERIOD = 10ns;

    localparam logic [2:0] A_MASK = 3'd0, A_UNMASK = 3'd1, A_MASKSET = 3'd2,
                           A_STATUS = 3'd3, A_KIND = 3'd4, A_SENSE = 3'd5,
                           A_BOTH = 3'd6, A_SPARE = 3'd7;
    localparam logic [NP-1:0] ONES = {NP{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_lvl = ONES;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [NP-1:0] reg_wdata = '0;
    logic [NP-1:0] reg_rdata;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;

    gpio_irq_unit #(.NPINS(NP)) i_gpio_irq_unit (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [NP-1:0] got,
                         input logic [NP-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Write on one edge; returns at the falling edge after it takes effect.
    task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // Write and change pins for the same clock edge.
    task automatic wr_pins(input logic [2:0] a, input logic [NP-1:0] d,
                           input logic [NP-1:0] p);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; pin_lvl = p;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pins(input logic [NP-1:0] p);
        @(negedge clk);
        pin_lvl = p;
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [NP-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic setup(input logic [NP-1:0] k, input logic [NP-1:0] s,
                         input logic [NP-1:0] b);
        pins(ONES);
        wr(A_KIND, k); wr(A_SENSE, s); wr(A_BOTH, b);
        wr(A_STATUS, ONES);
    endtask

    task automatic t_reset();
        logic [NP-1:0] v;
        rd(A_MASK, v);   check("R1 mask", v, ONES);
        rd(A_STATUS, v); check("R1 status", v, '0);
        rst_n = 1'b1;
        step(); step();
        rd(A_MASK, v);   check("R1 mask after", v, ONES);
        rd(A_STATUS, v); check("R1 status after", v, '0);
        rd(A_KIND, v);   check("R1 kind", v, '0);
        rd(A_SENSE, v);  check("R1 sense", v, '0);
        rd(A_BOTH, v);   check("R1 both", v, '0);
        check("R1 irq", {31'd0, irq}, '0);
    endtask

    task automatic t_map();
        logic [NP-1:0] v;
        wr(A_KIND, 32'h0000_0000);
        wr(A_BOTH, 32'h00A5_0000); rd(A_BOTH, v); check("R2 both rw", v, 32'h00A5_0000);
        wr(A_BOTH, '0);
        rd(A_UNMASK, v);  check("R2 unmask reads 0", v, '0);
        rd(A_MASKSET, v); check("R2 maskset reads 0", v, '0);
        rd(A_SPARE, v);   check("R2 spare reads 0", v, '0);
    endtask

    task automatic t_edges();
        logic [NP-1:0] v;
        setup(32'h3, 32'h1, 32'h0);
        pins(ONES & ~32'h1);
        rd(A_STATUS, v); check("R3 rising ignores fall", v, '0);
        pins(ONES);
        rd(A_STATUS, v); check("R3 rising sets", v, 32'h1);
        pins(ONES & ~32'h2);
        rd(A_STATUS, v); check("R3 falling sets", v, 32'h3);
        pins(ONES);
        rd(A_STATUS, v); check("R3 falling ignores rise", v, 32'h3);
        setup('0, '0, '0);
    endtask

    task automatic t_both();
        logic [NP-1:0] v;
        setup(32'h4, 32'h0, 32'hC);
        pins(ONES & ~32'h4);
        rd(A_STATUS, v); check("R4 both fall", v, 32'h4);
        wr(A_STATUS, 32'h4);
        pins(ONES);
        rd(A_STATUS, v); check("R4 both rise despite sense", v, 32'h4);
        wr(A_STATUS, 32'h4);
        pins(ONES & ~32'h8);
        wr_pins(A_STATUS, 32'h8, ONES);
        rd(A_STATUS, v); check("R4 both ignored in level", v, '0);
        setup('0, '0, '0);
    endtask

    task automatic t_level();
        logic [NP-1:0] v;
        setup(32'h0, 32'h10, 32'h0);
        step();
        rd(A_STATUS, v); check("R5 level high sets", v, 32'h10);
        wr(A_STATUS, 32'h10);
        rd(A_STATUS, v); check("R5 clear while held", v, 32'h10);
        pins(ONES & ~32'h10);
        wr(A_STATUS, 32'h10);
        rd(A_STATUS, v); check("R5 clear after release", v, '0);
        setup('0, '0, '0);
    endtask

    task automatic t_mask();
        logic [NP-1:0] v;
        setup(32'h20, 32'h20, 32'h0);
        pins(ONES & ~32'h20);
        pins(ONES);
        step();
        rd(A_STATUS, v); check("R9 latched while masked", v, 32'h20);
        check("R9 irq quiet while masked", {31'd0, irq}, '0);
        wr(A_UNMASK, 32'h20);
        rd(A_MASK, v); check("R6 unmask one bit", v, ~32'h20);
        step();
        check("R9 irq after unmask", {31'd0, irq}, 32'h1);
        wr(A_MASKSET, 32'h20);
        step();
        check("R10 irq drops when masked", {31'd0, irq}, '0);
        wr(A_UNMASK, 32'h20);
        wr(A_STATUS, 32'h20);
        step();
        check("R10 irq drops on clear", {31'd0, irq}, '0);
        wr(A_UNMASK, 32'hF0F0);
        rd(A_MASK, v); check("R6 zero bits keep", v, ~32'hF0F0 & ~32'h20);
        wr(A_MASKSET, ONES);
        rd(A_MASK, v); check("R6 all ones masks all", v, ONES);
        setup('0, '0, '0);
    endtask

    task automatic t_clear();
        logic [NP-1:0] v;
        setup(32'hC0, 32'hC0, 32'h0);
        pins(ONES & ~32'hC0);
        pins(ONES);
        wr(A_STATUS, 32'h0);
        rd(A_STATUS, v); check("R7 zero write keeps", v, 32'hC0);
        wr(A_STATUS, 32'h40);
        rd(A_STATUS, v); check("R7 clears one bit", v, 32'h80);
        setup('0, '0, '0);
    endtask

    task automatic t_race();
        logic [NP-1:0] v;
        setup(32'h100, 32'h100, 32'h0);
        pins(ONES & ~32'h100);
        wr_pins(A_STATUS, 32'h100, ONES);
        rd(A_STATUS, v); check("R8 event beats clear", v, 32'h100);
        wr(A_STATUS, 32'h100);
        rd(A_STATUS, v); check("R8 plain clear", v, '0);
        setup('0, '0, '0);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        t_map();
        t_edges();
        t_both();
        t_level();
        t_mask();
        t_clear();
        t_race();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule